// File: doc/BRIEF.md
# Partitioned SIMD Scalar Left Shifter

This block is a purely combinational left shifter for a 24-bit word. Two cut inputs split the word into lanes. Cut bit 0 splits it at bit 8, and cut bit 1 splits it at bit 16. All cuts open gives a single 24-bit lane. One cut gives one 8-bit lane and one 16-bit lane. Both cuts give three 8-bit lanes.

One scalar amount drives every lane. Each lane moves its own slice toward higher bit positions and fills the freed low positions with zeros. Bits pushed past the top of a lane are lost; they never enter the lane above.

Each lane keeps only as many low bits of the amount as its width needs: 3 bits for an 8-bit lane, 4 bits for a 16-bit lane, 5 bits for the 24-bit lane. A vector unit can use the block for byte, half-word and full-word shifts, changing the lane layout on every operation.

Top module: `lane_split_shl`

## Requirements
- R1: With cut_i = 2'b00 the whole word is one lane: word_o equals (word_i << amt_i) truncated to 24 bits, using all 5 bits of amt_i.
- R2: With cut_i = 2'b01, word_o[7:0] is word_i[7:0] shifted by amt_i[2:0], and word_o[23:8] is word_i[23:8] shifted by amt_i[3:0]. Each lane is truncated to its own width.
- R3: With cut_i = 2'b10, word_o[15:0] is word_i[15:0] shifted by amt_i[3:0], and word_o[23:16] is word_i[23:16] shifted by amt_i[2:0].
- R4: With cut_i = 2'b11, each byte word_o[8k+7:8k] (k = 0, 1, 2) is the matching byte of word_i shifted by amt_i[2:0].
- R5: No bit moves across an active cut, and the lowest bit of each lane is 0 whenever that lane's masked amount is non-zero (zero fill).
- R6: With cut_i = 2'b00 and amt_i in 24..31, word_o is all zeros.
- R7: A lane whose masked amount is zero passes its input slice through unchanged.
- R8: word_o follows every input change with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_i | input | 24 | Data word to shift |
| amt_i | input | 5 | Scalar shift amount shared by all lanes |
| cut_i | input | 2 | Lane cut enables; bit 0 splits at bit 8, bit 1 splits at bit 16 |
| word_o | output | 24 | Shifted word |

## Verification
The bench drives all-ones words through every cut setting at every amount from 0 to 31. A design that leaked bits across a cut would show ones in the low bits of the upper lane.

Amounts of 8 to 15 on 8-bit lanes catch a design that skips masking: such a design would clear the lane instead of wrapping the amount. Amounts of 16 to 31 on 16-bit lanes catch the same fault there.

Directed cases cover:
- single-lane amounts of 24 and above, which must clear the word;
- the top bit of a lane shifted by one, which must vanish rather than carry into the next lane.

Random words then cover the remaining mixes of data and amount.

// File: rtl/lss_pkg.sv
package lss_pkg;

    // Mask of amount bits a lane of lane_bits width honours: 2^ceil(log2(w)) - 1
    function automatic int unsigned amt_mask_for(input int unsigned lane_bits);
        int unsigned nbits;
        nbits = 0;
        for (int k = 0; k < 31; k++) begin
            if ((32'd1 << k) < lane_bits) nbits = k + 1;
        end
        return (32'd1 << nbits) - 1;
    endfunction

endpackage

// File: rtl/lss_lane_bounds.sv
module lss_lane_bounds #(
    parameter int NSEG  = 3,
    parameter int IDX_W = 2,
    parameter int SEG   = 0
) (
    input  logic [NSEG-2:0]  cut_i,
    output logic [IDX_W-1:0] lo_o,
    output logic [IDX_W-1:0] hi_o
);

    logic open_dn;
    logic open_up;

    // Walk down and up from this segment until an active cut is met
    always_comb begin
        lo_o    = IDX_W'(SEG);
        hi_o    = IDX_W'(SEG);
        open_dn = 1'b1;
        open_up = 1'b1;
        for (int k = SEG; k > 0; k--) begin
            if (open_dn && !cut_i[k-1]) lo_o = IDX_W'(k - 1);
            else                        open_dn = 1'b0;
        end
        for (int k = SEG; k < NSEG - 1; k++) begin
            if (open_up && !cut_i[k]) hi_o = IDX_W'(k + 1);
            else                      open_up = 1'b0;
        end
    end

    // R5: a segment always lies inside its own lane
    always_comb begin
        a_r5_lane_contains_seg: assert (int'(lo_o) <= SEG && int'(hi_o) >= SEG);
    end

endmodule

// File: rtl/lss_seg_shift.sv
module lss_seg_shift #(
    parameter int DATA_W = 24,
    parameter int SEG_W  = 8,
    parameter int NSEG   = 3,
    parameter int IDX_W  = 2,
    parameter int AMT_W  = 5,
    parameter int SEG    = 0
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic [IDX_W-1:0]  lo_i,
    input  logic [IDX_W-1:0]  hi_i,
    output logic [SEG_W-1:0]  slice_o
);

    int unsigned       lane_bits;
    logic [AMT_W-1:0]  amt_m;
    logic [DATA_W-1:0] lane_keep;
    logic [DATA_W-1:0] lane_word;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        lane_bits = (int'(hi_i) - int'(lo_i) + 1) * SEG_W;
        amt_m     = AMT_W'(int'(amt_i) & lss_pkg::amt_mask_for(lane_bits));
        for (int b = 0; b < DATA_W; b++) begin
            lane_keep[b] = (b >= int'(lo_i) * SEG_W) && (b < (int'(hi_i) + 1) * SEG_W);
        end
        // Bits outside the lane are cleared, so nothing from below can enter it
        lane_word = word_i & lane_keep;
        shifted   = lane_word << amt_m;
        slice_o   = shifted[SEG*SEG_W +: SEG_W];
    end

    always_comb begin
        if (amt_m == '0) begin
            a_r7_zero_amt_passes: assert (slice_o == word_i[SEG*SEG_W +: SEG_W]);
        end
        if (int'(lo_i) == SEG && amt_m != '0) begin
            a_r5_zero_fill: assert (slice_o[0] == 1'b0);
        end
    end

endmodule

// File: rtl/lane_split_shl.sv
module lane_split_shl #(
    parameter int DATA_W = 24,
    parameter int SEG_W  = 8,
    parameter int AMT_W  = 5
) (
    input  logic [DATA_W-1:0]        word_i,
    input  logic [AMT_W-1:0]         amt_i,
    input  logic [DATA_W/SEG_W-2:0]  cut_i,
    output logic [DATA_W-1:0]        word_o
);

    localparam int NSEG  = DATA_W / SEG_W;
    localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic [IDX_W-1:0] lo;
        logic [IDX_W-1:0] hi;
        logic [SEG_W-1:0] byte_ref;

        lss_lane_bounds #(
            .NSEG (NSEG),
            .IDX_W(IDX_W),
            .SEG  (g)
        ) u_bounds (
            .cut_i(cut_i),
            .lo_o (lo),
            .hi_o (hi)
        );

        lss_seg_shift #(
            .DATA_W(DATA_W),
            .SEG_W (SEG_W),
            .NSEG  (NSEG),
            .IDX_W (IDX_W),
            .AMT_W (AMT_W),
            .SEG   (g)
        ) u_shift (
            .word_i (word_i),
            .amt_i  (amt_i),
            .lo_i   (lo),
            .hi_i   (hi),
            .slice_o(word_o[g*SEG_W +: SEG_W])
        );

        // R4: with every cut active, each segment is an independent lane
        always_comb begin
            byte_ref = word_i[g*SEG_W +: SEG_W] << (int'(amt_i) & lss_pkg::amt_mask_for(SEG_W));
            if (&cut_i) begin
                a_r4_segment_lanes: assert (word_o[g*SEG_W +: SEG_W] == byte_ref);
            end
        end
    end

    // R6: one full lane with an amount at or past its width clears the word
    always_comb begin
        if (cut_i == '0 && (int'(amt_i) & lss_pkg::amt_mask_for(DATA_W)) >= DATA_W) begin
            a_r6_full_clear: assert (word_o == '0);
        end
    end

endmodule

// File: tb/lane_split_shl_test.sv
module lane_split_shl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] word_i = '0;
    logic [4:0]  amt_i = '0;
    logic [1:0]  cut_i = '0;
    logic [23:0] word_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lane_split_shl uut (
        .word_i(word_i),
        .amt_i (amt_i),
        .cut_i (cut_i),
        .word_o(word_o)
    );

    function automatic logic [23:0] model(input logic [23:0] d, input logic [4:0] a,
                                          input logic [1:0] c);
        logic [23:0] r;
        r = '0;
        case (c)
            2'b00: r = d << a;
            2'b01: begin
                r[7:0]  = d[7:0]  << a[2:0];
                r[23:8] = d[23:8] << a[3:0];
            end
            2'b10: begin
                r[15:0]  = d[15:0]  << a[3:0];
                r[23:16] = d[23:16] << a[2:0];
            end
            default: begin
                r[7:0]   = d[7:0]   << a[2:0];
                r[15:8]  = d[15:8]  << a[2:0];
                r[23:16] = d[23:16] << a[2:0];
            end
        endcase
        return r;
    endfunction

    function automatic string tag_for(input logic [1:0] c);
        case (c)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic [23:0] exp);
        total++;
        if (word_o !== exp) begin
            bad++;
            $display("FAIL %s: cut=%b amt=%0d data=%h actual=%h expected=%h",
                     req, cut_i, amt_i, word_i, word_o, exp);
        end
    endtask

    task automatic apply(input logic [23:0] d, input logic [4:0] a, input logic [1:0] c);
        @(negedge clk);
        word_i = d;
        amt_i  = a;
        cut_i  = c;
        #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: zero inputs give zero output
        apply(24'h0, 5'd0, 2'b00);
        check("R1 idle", 24'h0);

        // R6: single lane, large amounts clear
        apply(24'hFFFFFF, 5'd24, 2'b00);
        check("R6", 24'h0);
        apply(24'hABCDEF, 5'd31, 2'b00);
        check("R6", 24'h0);

        // R5: top bit of a lane must not carry into the next lane
        apply(24'h000080, 5'd1, 2'b01);
        check("R5", 24'h000000);
        apply(24'h008000, 5'd1, 2'b10);
        check("R5", 24'h000000);
        apply(24'hFFFFFF, 5'd1, 2'b11);
        check("R5", 24'hFEFEFE);
        apply(24'h000080, 5'd1, 2'b00);
        check("R1 carry inside lane", 24'h000100);

        // R7: masked amount of zero passes through (8 on byte lanes, 16 on half lanes)
        apply(24'h5A3C96, 5'd8, 2'b11);
        check("R7", 24'h5A3C96);
        apply(24'h5A3C96, 5'd16, 2'b10);
        check("R7", {8'h5A, 16'h3C96} & 24'hFFFFFF);

        // R8: output changes mid-cycle with no clock edge
        @(negedge clk);
        word_i = 24'h000001;
        amt_i  = 5'd4;
        cut_i  = 2'b00;
        #0.5;
        check("R8", 24'h000010);
        amt_i = 5'd5;
        #0.5;
        check("R8", 24'h000020);

        // Sweep: every cut, every amount, all-ones plus random words
        for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < 32; a++) begin
                apply(24'hFFFFFF, 5'(a), 2'(c));
                check(tag_for(2'(c)), model(24'hFFFFFF, 5'(a), 2'(c)));
                for (int n = 0; n < 3; n++) begin
                    logic [23:0] d;
                    d = 24'($urandom);
                    apply(d, 5'(a), 2'(c));
                    check(tag_for(2'(c)), model(d, 5'(a), 2'(c)));
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule